// File: doc/BRIEF.md
# Shared PLL Power Sequencer

This block controls the single enable line of a PLL that two PHY ports share. Each port asks for the clock with an init strobe and gives it up with an exit strobe. The sequencer keeps a count of the ports that are active. It powers the PLL up for the first user and keeps it running while any port still holds it. It turns the PLL off only when the last user leaves. Each request is answered with a one-cycle ack pulse or a one-cycle err pulse on the requesting port's lane.

All waits are counted in pulses of a 1 µs tick input, so the timing does not depend on the system clock. There are two timed actions. The first is the power-down pulse that precedes a reprogramming, held for at least `PD_US` ticks. The second is the wait for the worst-case lock time, at least `LOCK_US` ticks. After each wait the sequencer checks the enable readback. It does not use a lock flag. An external configuration step reports through `cfg_bad_i` whether the input clock is out of range. When the clock is accepted, the configuration word is captured at the load strobe.

Top module: `pll_share_seq`

## Requirements
- R1: After reset `pll_en_o`, `cfg_load_o`, `active_o`, `ack_o` and `err_o` are all 0, and no lane ever shows ack and err in the same cycle.
- R2: An init arriving while `pll_en_o` is 1 and at least one port is active sets the port's `active_o` bit and acks two clocks after the strobe. There is no load pulse and `pll_en_o` does not change.
- R3: An init arriving while `pll_en_o` is 1 and no port is active first drives `pll_en_o` low. The load pulse comes only after at least `PD_US` ticks with the enable low.
- R4: When the configuration is accepted, `pll_en_o` rises one cycle after the `cfg_load_o` pulse. The response comes only after at least `LOCK_US` further ticks. If `pll_en_rb_i` is 1 at that point, the port acks and its `active_o` bit is set in the same cycle.
- R5: If `pll_en_rb_i` is 0 after the lock wait, the init answers err, the port stays inactive and `pll_en_o` stays 1.
- R6: If `cfg_bad_i` is 1 in the load step, the init answers err, `cfg_load_o` does not pulse and `pll_en_o` stays 0.
- R7: An exit clears the port's `active_o` bit. If the other port is still active, the exit acks two clocks after the strobe and `pll_en_o` stays 1.
- R8: An exit by the last active port drops `pll_en_o` and waits at least `PD_US` ticks. It then answers err if `pll_en_rb_i` is 1 and ack otherwise.
- R9: Requests are served one at a time, so at most one lane responds in any cycle. When both ports strobe in the same cycle, port 0 is served first.
- R10: On the `cfg_load_o` pulse, `pll_cfg_o` holds the value of `cfg_word_i` sampled in the cycle before.
- R11: A strobe on a port whose earlier request has not yet been answered is ignored. If a port strobes init and exit together, the init is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| init_i | input | NP | Per-port init request strobe |
| exit_i | input | NP | Per-port exit request strobe |
| ack_o | output | NP | Per-port success pulse |
| err_o | output | NP | Per-port failure pulse |
| active_o | output | NP | Ports currently holding the PLL |
| cfg_word_i | input | CFG_W | PLL configuration computed for the current input clock |
| cfg_bad_i | input | 1 | Input clock out of range; configuration rejected |
| cfg_load_o | output | 1 | One-cycle strobe loading `pll_cfg_o` into the PLL |
| pll_cfg_o | output | CFG_W | Captured configuration word |
| pll_en_o | output | 1 | PLL enable |
| pll_en_rb_i | input | 1 | Enable readback from the PLL |

## Verification
The two functions that can meet in one cycle are request capture for both ports and the service of a request already in flight. Two init strobes issued in the same cycle from the powered-down state check that port 0 alone gets the slow power-up sequence. They also check that port 1 then takes the fast already-running path. An exit strobed on port 1 while its own init is still in service must leave no trace: exactly one response arrives and the port stays active. Random traffic then mixes inits, exits, stuck readbacks and rejected configurations, and each outcome is compared against a reference-count model.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PD,
    S_LOAD,
    S_EN,
    S_LOCK,
    S_OFF
  } seq_state_e;
endpackage

// File: rtl/pll_req_arb.sv
module pll_req_arb #(
  parameter int NP = 2,
  parameter int PW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] init_i,
  input  logic [NP-1:0] exit_i,
  input  logic [NP-1:0] busy_i,
  input  logic          take_i,
  output logic          req_vld_o,
  output logic [PW-1:0] req_port_o,
  output logic          req_exit_o
);
  logic [NP-1:0] pend_q, pexit_q;

  always_comb begin
    req_port_o = '0;
    for (int i = NP - 1; i >= 0; i--)
      if (pend_q[i]) req_port_o = PW'(i);
  end
  assign req_vld_o  = |pend_q;
  assign req_exit_o = pexit_q[req_port_o];

  for (genvar g = 0; g < NP; g++) begin : g_port
    logic acc, clr;
    assign acc = (init_i[g] | exit_i[g]) & ~pend_q[g] & ~busy_i[g];
    assign clr = take_i && (req_port_o == PW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[g]  <= 1'b0;
        pexit_q[g] <= 1'b0;
      end else if (acc) begin
        pend_q[g]  <= 1'b1;
        pexit_q[g] <= ~init_i[g];  // init wins on a tie
      end else if (clr) begin
        pend_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pll_us_timer.sv
module pll_us_timer #(
  parameter int PD_US   = 5,
  parameter int LOCK_US = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic lock_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int MAXT = (LOCK_US > PD_US) ? LOCK_US + 1 : PD_US + 1;
  localparam int CW   = $clog2(MAXT + 1) + 1;
  // one extra tick: first tick may land right after the window opens
  localparam logic [CW-1:0] PD_T   = CW'(PD_US + 1);
  localparam logic [CW-1:0] LOCK_T = CW'(LOCK_US + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = cnt_q >= (lock_i ? LOCK_T : PD_T);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int NP    = 2,
  parameter int PW    = 1,
  parameter int CFG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_vld_i,
  input  logic [PW-1:0]    req_port_i,
  input  logic             req_exit_i,
  output logic             take_o,
  output logic [NP-1:0]    busy_o,
  input  logic             cfg_bad_i,
  input  logic [CFG_W-1:0] cfg_word_i,
  input  logic             pll_en_rb_i,
  input  logic             t_done_i,
  output logic             t_run_o,
  output logic             t_lock_o,
  output logic             pll_en_o,
  output logic             cfg_load_o,
  output logic [CFG_W-1:0] pll_cfg_o,
  output logic [NP-1:0]    ack_o,
  output logic [NP-1:0]    err_o,
  output logic [NP-1:0]    active_o
);
  seq_state_e       state_q;
  logic [PW-1:0]    port_q;
  logic             en_q, load_q;
  logic [CFG_W-1:0] cfg_q;
  logic [NP-1:0]    act_q, ack_q, err_q;
  logic [NP-1:0]    req_oh, port_oh;

  assign req_oh  = {{(NP-1){1'b0}}, 1'b1} << req_port_i;
  assign port_oh = {{(NP-1){1'b0}}, 1'b1} << port_q;

  assign take_o   = (state_q == S_IDLE) && req_vld_i;
  assign busy_o   = (state_q != S_IDLE) ? port_oh : '0;
  assign t_run_o  = (state_q == S_PD) || (state_q == S_LOCK) || (state_q == S_OFF);
  assign t_lock_o = (state_q == S_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      port_q  <= '0;
      en_q    <= 1'b0;
      load_q  <= 1'b0;
      cfg_q   <= '0;
      act_q   <= '0;
      ack_q   <= '0;
      err_q   <= '0;
    end else begin
      ack_q  <= '0;
      err_q  <= '0;
      load_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_vld_i) begin
          port_q <= req_port_i;
          if (!req_exit_i) begin
            if (en_q && |act_q) begin
              act_q <= act_q | req_oh;
              ack_q <= req_oh;
            end else if (en_q) begin
              en_q    <= 1'b0;  // power-down pulse before reprogramming
              state_q <= S_PD;
            end else begin
              state_q <= S_LOAD;
            end
          end else begin
            act_q <= act_q & ~req_oh;
            if (|(act_q & ~req_oh)) begin
              ack_q <= req_oh;
            end else begin
              en_q    <= 1'b0;
              state_q <= S_OFF;
            end
          end
        end
        S_PD: if (t_done_i) state_q <= S_LOAD;
        S_LOAD: begin
          if (cfg_bad_i) begin
            err_q   <= port_oh;
            state_q <= S_IDLE;
          end else begin
            cfg_q   <= cfg_word_i;
            load_q  <= 1'b1;
            state_q <= S_EN;
          end
        end
        S_EN: begin
          en_q    <= 1'b1;
          state_q <= S_LOCK;
        end
        S_LOCK: if (t_done_i) begin
          if (pll_en_rb_i) begin
            act_q <= act_q | port_oh;
            ack_q <= port_oh;
          end else begin
            err_q <= port_oh;
          end
          state_q <= S_IDLE;
        end
        S_OFF: if (t_done_i) begin
          if (pll_en_rb_i) err_q <= port_oh;
          else             ack_q <= port_oh;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pll_en_o   = en_q;
  assign cfg_load_o = load_q;
  assign pll_cfg_o  = cfg_q;
  assign ack_o      = ack_q;
  assign err_o      = err_q;
  assign active_o   = act_q;
endmodule

// File: rtl/pll_share_seq.sv
module pll_share_seq #(
  parameter int NP      = 2,
  parameter int CFG_W   = 32,
  parameter int PD_US   = 5,
  parameter int LOCK_US = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_us_i,
  input  logic [NP-1:0]    init_i,
  input  logic [NP-1:0]    exit_i,
  output logic [NP-1:0]    ack_o,
  output logic [NP-1:0]    err_o,
  output logic [NP-1:0]    active_o,
  input  logic [CFG_W-1:0] cfg_word_i,
  input  logic             cfg_bad_i,
  output logic             cfg_load_o,
  output logic [CFG_W-1:0] pll_cfg_o,
  output logic             pll_en_o,
  input  logic             pll_en_rb_i
);
  localparam int PW = (NP > 1) ? $clog2(NP) : 1;

  logic          req_vld, req_exit, take, t_run, t_lock, t_done;
  logic [PW-1:0] req_port;
  logic [NP-1:0] busy;

  pll_req_arb #(.NP(NP), .PW(PW)) u_arb (
    .clk_i, .rst_ni, .init_i, .exit_i,
    .busy_i(busy), .take_i(take),
    .req_vld_o(req_vld), .req_port_o(req_port), .req_exit_o(req_exit)
  );

  pll_us_timer #(.PD_US(PD_US), .LOCK_US(LOCK_US)) u_tmr (
    .clk_i, .rst_ni, .run_i(t_run), .lock_i(t_lock),
    .tick_i(tick_us_i), .done_o(t_done)
  );

  pll_seq_fsm #(.NP(NP), .PW(PW), .CFG_W(CFG_W)) u_fsm (
    .clk_i, .rst_ni,
    .req_vld_i(req_vld), .req_port_i(req_port), .req_exit_i(req_exit),
    .take_o(take), .busy_o(busy),
    .cfg_bad_i, .cfg_word_i, .pll_en_rb_i,
    .t_done_i(t_done), .t_run_o(t_run), .t_lock_o(t_lock),
    .pll_en_o, .cfg_load_o, .pll_cfg_o, .ack_o, .err_o, .active_o
  );
endmodule

// File: rtl/pll_share_seq_chk.sv
module pll_share_seq_chk #(
  parameter int NP    = 2,
  parameter int CFG_W = 32,
  parameter int PD_US = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_us_i,
  input logic [NP-1:0]    ack_o,
  input logic [NP-1:0]    err_o,
  input logic [NP-1:0]    active_o,
  input logic             cfg_bad_i,
  input logic             cfg_load_o,
  input logic [CFG_W-1:0] cfg_word_i,
  input logic [CFG_W-1:0] pll_cfg_o,
  input logic             pll_en_o
);
  logic [15:0] low_ticks;
  logic        seen_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_ticks <= '0;
      seen_fall <= 1'b0;
    end else begin
      if (pll_en_o) low_ticks <= '0;
      else if (tick_us_i && low_ticks != 16'hFFFF) low_ticks <= low_ticks + 1'b1;
      if ($fell(pll_en_o)) seen_fall <= 1'b1;
    end
  end

  // R1
  ack_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o & err_o) == '0);

  // R9
  one_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o | err_o));

  // R4
  en_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_en_o) |-> $past(cfg_load_o));

  // R6
  load_good_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_o |-> $past(!cfg_bad_i));

  // R10
  cfg_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_o |-> pll_cfg_o == $past(cfg_word_i));

  // R3
  pd_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_load_o && seen_fall) |-> low_ticks >= 16'(PD_US));

  for (genvar g = 0; g < NP; g++) begin : g_act
    // R4
    act_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(active_o[g]) |-> ack_o[g]);
  end
endmodule

bind pll_share_seq pll_share_seq_chk #(.NP(NP), .CFG_W(CFG_W), .PD_US(PD_US)) u_chk (.*);

// File: tb/sim_pll_share_seq.sv
`timescale 1ns/100ps
module sim_pll_share_seq;
  localparam int NP = 2, CFG_W = 32, PD_US = 5, LOCK_US = 100, TICK_DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [NP-1:0] init_s = '0, exit_s = '0, ack, err, act;
  logic [CFG_W-1:0] cfg_word = '0, cfg_out;
  logic cfg_bad = 1'b0, load, en, rb;
  int   rb_mode = 0;  // 0 follow, 1 stuck low, 2 stuck high

  always #2.5 clk = ~clk;
  assign rb = (rb_mode == 0) ? en : (rb_mode == 2);

  pll_share_seq #(.NP(NP), .CFG_W(CFG_W), .PD_US(PD_US), .LOCK_US(LOCK_US)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick), .init_i(init_s), .exit_i(exit_s),
    .ack_o(ack), .err_o(err), .active_o(act), .cfg_word_i(cfg_word), .cfg_bad_i(cfg_bad),
    .cfg_load_o(load), .pll_cfg_o(cfg_out), .pll_en_o(en), .pll_en_rb_i(rb));

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    tick <= (tdiv == 0);
  end

  int nchk = 0, nfail = 0, loads = 0, low_ticks = 0, hi_ticks = 0, low_at_load = 0;
  int resp_cnt [NP];
  bit finished = 0;
  initial for (int i = 0; i < NP; i++) resp_cnt[i] = 0;

  always @(posedge clk) begin
    #1;
    if (en) begin low_ticks = 0; if (tick) hi_ticks++; end
    else begin hi_ticks = 0; if (tick) low_ticks++; end
    if (load) begin loads++; low_at_load = low_ticks; end
    for (int i = 0; i < NP; i++) if (ack[i] | err[i]) resp_cnt[i]++;
  end

  task automatic check(input bit ok, input string tag, input longint a, input longint e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  // reference model
  bit m_en = 0;
  bit [NP-1:0] m_act = '0;

  function automatic bit exp_init_ack(bit e, bit [NP-1:0] a, int mode, bit bad);
    if (e && a != 0) return 1;
    if (bad) return 0;
    return mode != 1;
  endfunction

  function automatic bit exp_exit_ack(bit [NP-1:0] a_after, int mode);
    if (a_after != 0) return 1;
    return mode != 2;
  endfunction

  task automatic wait_resp(input int p, output bit got_ack, output int cyc);
    cyc = 0; got_ack = 0;
    while (cyc < 5000) begin
      @(posedge clk); #1; cyc++;
      if (ack[p] | err[p]) begin got_ack = ack[p]; return; end
    end
    check(0, "watch response", cyc, 0);
  endtask

  task automatic do_req(input int p, input bit is_exit, input int mode, input bit bad);
    bit ga, ea, fast, slow; int cyc, l0, pre_low; bit [CFG_W-1:0] w;
    bit [NP-1:0] oh;
    oh = NP'(1) << p;
    w = $urandom;
    @(negedge clk);
    rb_mode = mode; cfg_bad = bad; cfg_word = w;
    l0 = loads;
    if (is_exit) exit_s = oh; else init_s = oh;
    @(negedge clk); init_s = '0; exit_s = '0;
    wait_resp(p, ga, cyc);
    if (!is_exit) begin
      fast = m_en && m_act != 0;
      ea = exp_init_ack(m_en, m_act, mode, bad);
      check(ga == ea, "R5/R6 init outcome", ga, ea);
      if (fast) begin
        check(cyc == 1, "R2 fast ack latency", cyc + 1, 2);
        check(loads == l0, "R2 no reload", loads - l0, 0);
        check(en == 1, "R2 enable kept", en, 1);
      end else if (bad) begin
        check(loads == l0, "R6 no load", loads - l0, 0);
        check(en == 0, "R6 enable low", en, 0);
        m_en = 0;
      end else begin
        check(loads == l0 + 1, "R4 one load", loads - l0, 1);
        check(cfg_out == w, "R10 cfg captured", cfg_out, w);
        check(hi_ticks >= LOCK_US, "R4 lock wait", hi_ticks, LOCK_US);
        check(en == 1, "R5 enable high after lock", en, 1);
        if (m_en) check(low_at_load >= PD_US, "R3 power-down pulse", low_at_load, PD_US);
        m_en = 1;
      end
      if (ea) m_act |= oh;
    end else begin
      m_act &= ~oh;
      ea = exp_exit_ack(m_act, mode);
      check(ga == ea, "R7/R8 exit outcome", ga, ea);
      if (m_act != 0) begin
        check(cyc == 1, "R7 fast exit", cyc + 1, 2);
        check(en == m_en, "R7 enable kept", en, m_en);
      end else begin
        pre_low = low_ticks;
        check(en == 0, "R8 enable low", en, 0);
        check(pre_low >= PD_US, "R8 low width", pre_low, PD_US);
        m_en = 0;
      end
    end
    check(act == m_act, "R4/R7 active map", act, m_act);
    slow = 0;
    if (slow) check(0, "unused", 0, 0);
  endtask

  initial begin
    bit ga; int cyc, r0;
    void'($urandom(32'h5A17_3C01));
    repeat (3) @(negedge clk);
    check(en == 0 && act == 0 && ack == 0 && err == 0 && load == 0, "R1 reset state",
          {en, act, ack, err, load}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(en == 0 && act == 0, "R1 after release", {en, act}, 0);

    // R9 both ports strobe together from off
    @(negedge clk); rb_mode = 0; cfg_bad = 0; init_s = '1;
    @(negedge clk); init_s = '0;
    cyc = 0;
    while (cyc < 5000 && (ack | err) == 0) begin @(posedge clk); #1; cyc++; end
    check(ack == 2'b01, "R9 port 0 first", ack, 1);
    wait_resp(1, ga, cyc);
    check(ga && cyc <= 3, "R9 port 1 fast follow", cyc, 2);
    check(act == 2'b11, "R9 both active", act, 3);
    m_en = 1; m_act = 2'b11;
    do_req(0, 1, 0, 0);
    do_req(1, 1, 0, 0);

    // R11 exit strobed on port 1 while its init is in service
    @(negedge clk); init_s = 2'b10;
    @(negedge clk); init_s = '0;
    repeat (20) @(negedge clk);
    r0 = resp_cnt[1];
    exit_s = 2'b10;
    @(negedge clk); exit_s = '0;
    wait_resp(1, ga, cyc);
    repeat (1500) @(negedge clk);
    check(resp_cnt[1] == r0 + 1, "R11 single response", resp_cnt[1] - r0, 1);
    check(act == 2'b10, "R11 port stays active", act, 2);
    // R11 init+exit on the same port in one cycle: init wins
    @(negedge clk); init_s = 2'b01; exit_s = 2'b01;
    @(negedge clk); init_s = '0; exit_s = '0;
    wait_resp(0, ga, cyc);
    check(ga && act == 2'b11, "R11 init taken", act, 3);
    m_en = 1; m_act = 2'b11;
    do_req(0, 1, 0, 0);
    do_req(1, 1, 0, 0);

    // directed corners: lock fail, then reprogram with power-down (R3, R5)
    do_req(0, 0, 1, 0);
    do_req(1, 0, 0, 0);
    do_req(1, 1, 2, 0);   // R8 stuck-high readback
    do_req(0, 0, 0, 1);   // R6 bad clock

    for (int n = 0; n < 40; n++) begin
      int p, mode; bit ex, bad;
      p = $urandom % NP;
      ex = m_act[p] ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
      mode = ($urandom % 6 == 0) ? (ex ? 2 : 1) : 0;
      bad = ($urandom % 8 == 0);
      do_req(p, ex, mode, bad);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(5 * 190000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule